// File: doc/BRIEF.md
# DRAM Strobe Cycle Mode Decoder

This block watches the control strobes of a 16-bit DRAM bus whose row and column addresses share one set of pins. It has no storage array. A fast local clock samples the row strobe, the two byte column strobes, write enable and output enable. From the order of their edges, the block works out what kind of memory cycle the controller is running. The inputs are taken to be synchronous to that clock, and each bus change is seen as one sample.

At the end of each column access (the last byte strobe going high), the block issues a one-sample report. The report gives the cycle kind, whether it was a page-mode access, the row and column it captured, and the byte write mask. It also flags a violation when the two byte lanes were run under different write timing. Refresh cycles produce their report when the row strobe rises. A refresh started with a column strobe already low takes its row from an internal 9-bit counter, and that counter advances on each such cycle. A per-byte flag tells a bus model when read data should be driven. A separate flag, updated at every rise of the row strobe, records whether the row strobe stayed low for too long.

Mode codes on `rpt_mode`: 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 strobe-first refresh, 7 self-refresh. In every two-bit byte vector, bit 0 is the lower byte (`lcas_n`) and bit 1 is the upper byte (`ucas_n`).

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, `rpt_valid`=0, `rpt_mode`=0, `drive_en`=0, `ras_viol`=0, `rpt_byte_viol`=0 and `refresh_row`=0.
- R2: A row strobe fall with both column strobes high captures `addr` as the row. If no column access starts before the row strobe rises, then on the sample of that rise the block reports mode 5 with the captured row.
- R3: A row strobe fall with either column strobe low starts a refresh. Its row is the current `refresh_row`, which then increments by one and wraps from 511 to 0. The refresh is reported on the rise of the row strobe as mode 6.
- R4: If the row strobe of such a refresh was sampled low on at least SELF_CYC samples, the report is mode 7 instead of mode 6.
- R5: An access starts when the first byte strobe falls and captures `addr` as the column. It is reported on the sample where the last byte strobe rises, and not before. If write enable stays high for the whole access, the report is mode 1 with `rpt_wbe`=0.
- R6: If write enable is low on the sample where the access starts, the report is mode 2. `rpt_wbe` holds every byte whose strobe fell while write enable was low, and `drive_en` stays 0 even with output enable low.
- R7: If write enable falls during an access that began with it high, and output enable was never low before that, the report is mode 3. `rpt_wbe` holds the bytes whose strobes were low at the write enable fall.
- R8: If output enable was low during the access before write enable fell, the report is mode 4, with the same write mask rule as R7.
- R9: Within one row strobe low period, the first access reports `rpt_fast_page`=0 and each later access reports 1. All of them report the same captured row, and the rise of the row strobe gives no extra report.
- R10: `drive_en[b]` is 1 one sample after a sample in which an access was open and did not start as a write, write enable was high, output enable was low, and byte b's strobe was low. Otherwise it is 0.
- R11: If a byte strobe falls later within an open access with a write enable level different from the level at the start of the access, that access reports `rpt_byte_viol`=1.
- R12: When the row strobe rises at the end of a row cycle, `ras_viol` is set if it was sampled low on more than TRAS_MAX_CYC samples, and cleared otherwise. It holds between rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| rpt_valid | output | 1 | One-sample report pulse |
| rpt_mode | output | 3 | Cycle kind code |
| rpt_fast_page | output | 1 | Access was not the first in its row period |
| rpt_row | output | ADDR_W | Row of the reported cycle |
| rpt_col | output | ADDR_W | Column of the reported access |
| rpt_wbe | output | 2 | Byte write mask |
| rpt_byte_viol | output | 1 | Byte lanes used different write timing |
| ras_viol | output | 1 | Last row cycle exceeded the low-time limit |
| drive_en | output | 2 | Per-byte data drive request |
| refresh_row | output | ADDR_W | Next internal refresh row |

## Verification
The bench sweeps all four access kinds (read, early write, delayed write and read-modify-write) over all three byte masks, with three page accesses per row period. This separates the mode codes by write enable timing against output enable, and it separates first from later page accesses. Staggered byte strobes show that the report waits for the last rise, and that matched write timing is accepted while mixed timing is flagged. The refresh paths are driven with row strobe low times on each side of both thresholds, and the counter is run through a full wrap.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY    = 3'd0,
        MODE_READ       = 3'd1,
        MODE_EARLY_WR   = 3'd2,
        MODE_DELAYED_WR = 3'd3,
        MODE_RMW        = 3'd4,
        MODE_RAS_ONLY   = 3'd5,
        MODE_CBR        = 3'd6,
        MODE_SELF       = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROW     = 2'd1,
        ST_REFRESH = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/dsd_strobe_reg.sv
module dsd_strobe_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] now_n,
    output logic [N-1:0] prev_n
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb prev_d[i] = now_n[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= prev_d[i];
        end
    end

    assign prev_n = prev_q;
endmodule

// File: rtl/dsd_low_timer.sv
module dsd_low_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (start)                 count_d = W'(1);
        else if (run && !(&count_q)) count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    assert_timer_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> count == W'(1));
endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] row
);
    logic [W-1:0] row_d, row_q;

    always_comb row_d = bump ? row_q + W'(1) : row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    assert_refresh_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> row == $past(row) + W'(1));
    assert_refresh_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(row));
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
    parameter int ADDR_W       = 9,
    parameter int TRAS_MAX_CYC = 10000,
    parameter int SELF_CYC     = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rpt_valid,
    output logic [2:0]        rpt_mode,
    output logic              rpt_fast_page,
    output logic [ADDR_W-1:0] rpt_row,
    output logic [ADDR_W-1:0] rpt_col,
    output logic [1:0]        rpt_wbe,
    output logic              rpt_byte_viol,
    output logic              ras_viol,
    output logic [1:0]        drive_en,
    output logic [ADDR_W-1:0] refresh_row
);
    import dsd_pkg::*;

    localparam int LIMIT_MAX = (TRAS_MAX_CYC > SELF_CYC) ? TRAS_MAX_CYC : SELF_CYC;
    localparam int TW        = $clog2(LIMIT_MAX + 2);
    localparam logic [TW-1:0] TRAS_LIM = TW'(TRAS_MAX_CYC);
    localparam logic [TW-1:0] SELF_LIM = TW'(SELF_CYC);

    typedef struct packed {
        cyc_state_e        st;
        logic              started;
        logic              acc_open;
        logic              acc_early;
        logic              oe_seen;
        logic              acc_fp;
        logic              acc_viol;
        mode_e             acc_kind;
        logic [1:0]        wmask;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] ref_used;
        logic              rpt_valid;
        mode_e             rpt_mode;
        logic              rpt_fp;
        logic [ADDR_W-1:0] rpt_row;
        logic [ADDR_W-1:0] rpt_col;
        logic [1:0]        rpt_wbe;
        logic              rpt_viol;
        logic              ras_viol;
        logic [1:0]        drive;
    } dec_state_t;

    dec_state_t state_d, state_q;

    // strobe history: bit0 lower CAS, bit1 upper CAS, bit2 RAS, bit3 WE
    logic [3:0] strobes_now_n, strobes_prev_n;
    assign strobes_now_n = {we_n, ras_n, ucas_n, lcas_n};

    dsd_strobe_reg #(.N(4)) strobe_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .now_n  (strobes_now_n),
        .prev_n (strobes_prev_n)
    );

    logic [1:0] cas_n, cas_prev_n, byte_fall;
    logic       ras_fall, ras_rise, we_fall;
    logic       any_cas_now, any_cas_prev, comb_fall, comb_rise;
    logic       refresh_bump;
    logic [TW-1:0]     low_cnt;
    logic [ADDR_W-1:0] ref_row;

    always_comb begin
        cas_n        = {ucas_n, lcas_n};
        cas_prev_n   = strobes_prev_n[1:0];
        byte_fall    = cas_prev_n & ~cas_n;
        ras_fall     = strobes_prev_n[2] & ~ras_n;
        ras_rise     = ~strobes_prev_n[2] & ras_n;
        we_fall      = strobes_prev_n[3] & ~we_n;
        any_cas_now  = (cas_n != 2'b11);
        any_cas_prev = (cas_prev_n != 2'b11);
        comb_fall    = ~any_cas_prev & any_cas_now;
        comb_rise    = any_cas_prev & ~any_cas_now;
        refresh_bump = (state_q.st == ST_IDLE) && ras_fall && any_cas_now;
    end

    dsd_low_timer #(.W(TW)) low_timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ras_fall),
        .run   (~ras_n),
        .count (low_cnt)
    );

    dsd_refresh_ctr #(.W(ADDR_W)) refresh_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (refresh_bump),
        .row   (ref_row)
    );

    always_comb begin
        state_d = state_q;
        state_d.rpt_valid = 1'b0;

        // column access tracking, independent of the row state once open
        if (state_q.st == ST_ROW && comb_fall) begin
            state_d.acc_open  = 1'b1;
            state_d.acc_early = ~we_n;
            state_d.oe_seen   = we_n & ~oe_n;
            state_d.acc_fp    = state_q.started;
            state_d.started   = 1'b1;
            state_d.acc_viol  = 1'b0;
            state_d.acc_kind  = we_n ? MODE_READ : MODE_EARLY_WR;
            state_d.wmask     = we_n ? 2'b00 : ~cas_n;
            state_d.col       = addr;
        end else if (state_q.acc_open) begin
            if (|byte_fall) begin
                if ((~we_n) != state_q.acc_early) state_d.acc_viol = 1'b1;
                if (!we_n) state_d.wmask = state_q.wmask | byte_fall;
            end
            if (we_fall && !state_q.acc_early && state_q.acc_kind == MODE_READ) begin
                state_d.acc_kind = state_q.oe_seen ? MODE_RMW : MODE_DELAYED_WR;
                state_d.wmask    = state_q.wmask | ~cas_n;
            end
            if (!oe_n && we_n && !state_q.acc_early) state_d.oe_seen = 1'b1;
            if (comb_rise) begin
                state_d.acc_open  = 1'b0;
                state_d.rpt_valid = 1'b1;
                state_d.rpt_mode  = state_q.acc_kind;
                state_d.rpt_fp    = state_q.acc_fp;
                state_d.rpt_row   = state_q.row;
                state_d.rpt_col   = state_q.col;
                state_d.rpt_wbe   = state_d.wmask;
                state_d.rpt_viol  = state_d.acc_viol;
            end
        end

        // row strobe sequencing
        unique case (state_q.st)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!any_cas_now) begin
                        state_d.st      = ST_ROW;
                        state_d.row     = addr;
                        state_d.started = 1'b0;
                    end else begin
                        state_d.st       = ST_REFRESH;
                        state_d.ref_used = ref_row;
                    end
                end
            end
            ST_ROW: begin
                if (ras_rise) begin
                    state_d.st       = ST_IDLE;
                    state_d.ras_viol = (low_cnt > TRAS_LIM);
                    if (!state_q.started) begin
                        state_d.rpt_valid = 1'b1;
                        state_d.rpt_mode  = MODE_RAS_ONLY;
                        state_d.rpt_fp    = 1'b0;
                        state_d.rpt_row   = state_q.row;
                        state_d.rpt_wbe   = 2'b00;
                        state_d.rpt_viol  = 1'b0;
                    end
                end
            end
            ST_REFRESH: begin
                if (ras_rise) begin
                    state_d.st        = ST_IDLE;
                    state_d.ras_viol  = 1'b0;
                    state_d.rpt_valid = 1'b1;
                    state_d.rpt_mode  = (low_cnt >= SELF_LIM) ? MODE_SELF : MODE_CBR;
                    state_d.rpt_fp    = 1'b0;
                    state_d.rpt_row   = state_q.ref_used;
                    state_d.rpt_wbe   = 2'b00;
                    state_d.rpt_viol  = 1'b0;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase

        state_d.drive = (state_d.acc_open && !state_d.acc_early && we_n && !oe_n)
                        ? ~cas_n : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.st       <= ST_IDLE;
            state_q.acc_kind <= MODE_STANDBY;
            state_q.rpt_mode <= MODE_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    assign rpt_valid     = state_q.rpt_valid;
    assign rpt_mode      = state_q.rpt_mode;
    assign rpt_fast_page = state_q.rpt_fp;
    assign rpt_row       = state_q.rpt_row;
    assign rpt_col       = state_q.rpt_col;
    assign rpt_wbe       = state_q.rpt_wbe;
    assign rpt_byte_viol = state_q.rpt_viol;
    assign ras_viol      = state_q.ras_viol;
    assign drive_en      = state_q.drive;
    assign refresh_row   = ref_row;

    assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|drive_en) |-> !$past(oe_n));
    assert_drive_lower_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en[0] |-> !$past(lcas_n));
    assert_drive_upper_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en[1] |-> !$past(ucas_n));
    assert_read_no_wbe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_mode == 3'd1) |-> rpt_wbe == 2'b00);
    assert_write_has_wbe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && (rpt_mode == 3'd2 || rpt_mode == 3'd3 || rpt_mode == 3'd4))
        |-> rpt_wbe != 2'b00);
    assert_single_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);
    assert_refresh_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_mode >= 3'd6) |-> $past(ras_n) && !$past(ras_n, 2));
endmodule

// File: tb/dram_strobe_decoder_tb_top.sv
module dram_strobe_decoder_tb_top;
    localparam int AW   = 9;
    localparam int TRAS = 40;
    localparam int SELF = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic rpt_valid, rpt_fast_page, rpt_byte_viol, ras_viol;
    logic [2:0] rpt_mode;
    logic [AW-1:0] rpt_row, rpt_col, refresh_row;
    logic [1:0] rpt_wbe, drive_en;

    int n_checks = 0;
    int n_errors = 0;
    int ref_exp  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW), .TRAS_MAX_CYC(TRAS), .SELF_CYC(SELF)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .rpt_valid(rpt_valid),
        .rpt_mode(rpt_mode), .rpt_fast_page(rpt_fast_page), .rpt_row(rpt_row),
        .rpt_col(rpt_col), .rpt_wbe(rpt_wbe), .rpt_byte_viol(rpt_byte_viol),
        .ras_viol(ras_viol), .drive_en(drive_en), .refresh_row(refresh_row)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // kind: 0 read, 1 early write, 2 delayed write, 3 read-modify-write
    task automatic do_access(input logic [AW-1:0] col, input logic [1:0] mask,
                             input int kind, input logic exp_fp, input logic [AW-1:0] row);
        logic [1:0] exp_drive;
        addr = col;
        if (kind == 1) we_n = 1'b0;
        {ucas_n, lcas_n} = ~mask;
        step(1);
        addr = ~col;
        if (kind != 2) begin
            oe_n = 1'b0;
            step(1);
            exp_drive = (kind == 1) ? 2'b00 : mask;
            chk(kind == 1 ? "R6 drive off in early write" : "R10 drive_en", 32'(drive_en), 32'(exp_drive));
        end
        step(1);
        oe_n = 1'b1;
        if (kind >= 2) we_n = 1'b0;
        step(1);
        chk("R7 no drive after WE fall", 32'(drive_en), 32'd0);
        {ucas_n, lcas_n} = 2'b11;
        step(1);
        chk("R5 report pulse", 32'(rpt_valid), 32'd1);
        chk("R5/R6/R7/R8 mode", 32'(rpt_mode), 32'(kind + 1));
        chk("R6/R7/R8 wbe", 32'(rpt_wbe), (kind == 0) ? 32'd0 : 32'(mask));
        chk("R9 fast page", 32'(rpt_fast_page), 32'(exp_fp));
        chk("R9 row", 32'(rpt_row), 32'(row));
        chk("R5 col", 32'(rpt_col), 32'(col));
        chk("R11 no violation", 32'(rpt_byte_viol), 32'd0);
        we_n = 1'b1;
        step(1);
    endtask

    task automatic ras_open(input logic [AW-1:0] row);
        addr = row;
        ras_n = 1'b0;
        step(1);
        addr = '0;
        step(1);
    endtask

    task automatic ras_close();
        ras_n = 1'b1;
        step(1);
        chk("R9 no report at RAS rise", 32'(rpt_valid), 32'd0);
        step(2);
    endtask

    task automatic ras_only(input logic [AW-1:0] row, input int k);
        addr = row;
        ras_n = 1'b0;
        step(1);
        addr = ~row;
        step(k - 1);
        ras_n = 1'b1;
        step(1);
        chk("R2 report", 32'(rpt_valid), 32'd1);
        chk("R2 mode", 32'(rpt_mode), 32'd5);
        chk("R2 row", 32'(rpt_row), 32'(row));
        chk("R12 ras_viol", 32'(ras_viol), (k > TRAS) ? 32'd1 : 32'd0);
        step(2);
    endtask

    task automatic cbr(input int k);
        lcas_n = 1'b0;
        step(1);
        ras_n = 1'b0;
        step(k);
        ras_n = 1'b1;
        step(1);
        chk("R3 report", 32'(rpt_valid), 32'd1);
        chk("R3/R4 mode", 32'(rpt_mode), (k >= SELF) ? 32'd7 : 32'd6);
        chk("R3 refresh row", 32'(rpt_row), 32'(ref_exp % 512));
        ref_exp++;
        chk("R3 counter", 32'(refresh_row), 32'(ref_exp % 512));
        lcas_n = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 valid", 32'(rpt_valid), 32'd0);
        chk("R1 mode", 32'(rpt_mode), 32'd0);
        chk("R1 drive", 32'(drive_en), 32'd0);
        chk("R1 ras_viol", 32'(ras_viol), 32'd0);
        chk("R1 byte_viol", 32'(rpt_byte_viol), 32'd0);
        chk("R1 refresh_row", 32'(refresh_row), 32'd0);

        // access sweep: every kind x every mask, three page accesses per row
        for (int kind = 0; kind < 4; kind++) begin
            for (int m = 1; m < 4; m++) begin
                logic [AW-1:0] row;
                row = AW'(kind * 37 + m * 101);
                ras_open(row);
                for (int p = 0; p < 3; p++)
                    do_access(AW'(row + p * 3 + 5), 2'(m), kind, (p != 0), row);
                ras_close();
                chk("R12 short cycle", 32'(ras_viol), 32'd0);
            end
        end

        // staggered read: report only at the later rise
        ras_open(9'h0AA);
        addr = 9'h033;
        lcas_n = 1'b0;
        step(1);
        ucas_n = 1'b0;
        step(1);
        lcas_n = 1'b1;
        step(1);
        chk("R5 no report before last rise", 32'(rpt_valid), 32'd0);
        ucas_n = 1'b1;
        step(1);
        chk("R5 staggered report", 32'(rpt_valid), 32'd1);
        chk("R5 staggered mode", 32'(rpt_mode), 32'd1);
        chk("R11 matched timing", 32'(rpt_byte_viol), 32'd0);
        ras_close();

        // mixed write timing between bytes
        ras_open(9'h155);
        addr = 9'h044;
        lcas_n = 1'b0;
        step(1);
        we_n = 1'b0;
        step(1);
        ucas_n = 1'b0;
        step(1);
        {ucas_n, lcas_n} = 2'b11;
        step(1);
        chk("R11 violation flagged", 32'(rpt_byte_viol), 32'd1);
        chk("R7 mixed mode", 32'(rpt_mode), 32'd3);
        chk("R7 mixed wbe", 32'(rpt_wbe), 32'd3);
        we_n = 1'b1;
        ras_close();

        // row-only refresh and low-time limit edges
        ras_only(9'h1F0, 5);
        ras_only(9'h00F, TRAS);
        ras_only(9'h123, TRAS + 1);
        ras_only(9'h0C3, TRAS);

        // refresh, self-refresh threshold, counter wrap
        cbr(SELF - 1);
        cbr(SELF);
        cbr(3);
        while (ref_exp < 515) cbr(2);

        finish_run();
    end
endmodule